// File: doc/BRIEF.md
# Multi-line programmable edge detector

This block watches 256 single-bit signals and raises a one-clock pulse on the matching output bit whenever a signal makes a transition of the kind chosen for it. Every signal has its own two-bit mode: rising only, falling only, or both directions. It also has its own suppress bit, which silences it without changing its mode. All inputs are treated as synchronous to `clk`. A separate stage upstream has to synchronise asynchronous sources.

Mode and suppress settings are held in a bank of 32-bit words. Software reads and writes them over a plain register port that has an address, a write strobe, write data and combinational read data. The detector registers each input, compares the newest sample with the one before it, and presents the per-line pulses together with a single flag that is high when any line fired. Both outputs change in the same cycle.

Top module: `multi_edge_detector`

## Requirements
- R1: An input transition applied before clock edge k appears on `edge_pulse` after edge k+1, two edges later. Only the line that changed is affected.
- R2: Mode code 2'b00 (rising) pulses a line when its previous sample is 0 and its current sample is 1, and on no other transition.
- R3: Mode code 2'b01 (falling) pulses a line on a 1-to-0 transition only.
- R4: Mode code 2'b10 (both) pulses a line on either transition.
- R5: Mode code 2'b11 is reserved, and a line set to it never pulses.
- R6: Suppress word n is at byte address 0x848+4n (n = 0..7), and line r uses bit r mod 32 of word r/32. A 1 blocks that line's pulse and a 0 lets it through.
- R7: Mode word n is at byte address 0x808+4n (n = 0..15), and line r uses bits [2(r mod 16)+1 : 2(r mod 16)] of word r/16.
- R8: Every mode word and suppress word reads back the value last written to it, with the full 32 bits.
- R9: A read of an address outside both ranges, or of an address with bits [1:0] not 00, returns 0. A write to such an address changes no register.
- R10: Reset clears every mode word and suppress word to 0 and clears the sample history. No pulse appears in the first cycles after reset, whatever level the inputs hold.
- R11: `any_edge` is high in exactly the cycles when at least one bit of `edge_pulse` is high.
- R12: A single transition followed by a steady level produces a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe; the word is written on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| lines_in | input | 256 | Observed signals, one per line |
| edge_pulse | output | 256 | Per-line one-cycle detection pulses |
| any_edge | output | 1 | OR of all bits of `edge_pulse` |

## Verification
The hardest cases to reach from the ports are those where a mode field or suppress bit sits at the top of its word, such as line 255 in bits 31:30 and bit 31. A shifted index still looks right on lines near zero, so these cases must be exercised directly. The stimulus writes raw words with only the top field set, then toggles line 255 both ways and checks that only bit 255 answers, and only in the chosen direction. The other hard case is the absence of a false pulse after reset. For this, all 256 inputs are held high through reset and the outputs are then watched while the sample history fills.

// File: rtl/edge_det_pkg.sv
package edge_det_pkg;

    typedef enum logic [1:0] {
        MODE_RISE = 2'b00,
        MODE_FALL = 2'b01,
        MODE_BOTH = 2'b10,
        MODE_RSVD = 2'b11
    } edge_mode_e;

    localparam int MODE_BITS = 2;

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs #(
    parameter int                NUM_LINES = 256,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 'h808,
    parameter logic [ADDR_W-1:0] MASK_BASE = 'h848
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [ADDR_W-1:0]                          reg_addr,
    input  logic                                       reg_wr_en,
    input  logic [DATA_W-1:0]                          reg_wdata,
    output logic [DATA_W-1:0]                          reg_rdata,
    output logic [edge_det_pkg::MODE_BITS*NUM_LINES-1:0] mode_flat,
    output logic [NUM_LINES-1:0]                       mask_flat
);
    localparam int CTRL_WORDS = (edge_det_pkg::MODE_BITS * NUM_LINES) / DATA_W;
    localparam int MASK_WORDS = NUM_LINES / DATA_W;
    localparam int CIDX_W     = $clog2(CTRL_WORDS);
    localparam int MIDX_W     = $clog2(MASK_WORDS);
    localparam int OFF_W      = ADDR_W - 2;
    localparam logic [OFF_W-1:0] CTRL_CNT = OFF_W'(CTRL_WORDS);
    localparam logic [OFF_W-1:0] MASK_CNT = OFF_W'(MASK_WORDS);

    typedef struct packed {
        logic [CTRL_WORDS-1:0][DATA_W-1:0] ctrl;
        logic [MASK_WORDS-1:0][DATA_W-1:0] mask;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [ADDR_W-1:0] ctrl_off, mask_off;
    logic              ctrl_hit, mask_hit;
    logic [CIDX_W-1:0] ctrl_idx;
    logic [MIDX_W-1:0] mask_idx;

    // Address decode: word-aligned hits inside each bank only
    always_comb begin
        ctrl_off = reg_addr - CTRL_BASE;
        mask_off = reg_addr - MASK_BASE;
        ctrl_hit = (reg_addr >= CTRL_BASE) && (ctrl_off[1:0] == 2'b00)
                   && (ctrl_off[ADDR_W-1:2] < CTRL_CNT);
        mask_hit = (reg_addr >= MASK_BASE) && (mask_off[1:0] == 2'b00)
                   && (mask_off[ADDR_W-1:2] < MASK_CNT);
        ctrl_idx = ctrl_off[CIDX_W+1:2];
        mask_idx = mask_off[MIDX_W+1:2];
    end

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_en && ctrl_hit) begin
            cfg_d.ctrl[ctrl_idx] = reg_wdata;
        end
        if (reg_wr_en && mask_hit) begin
            cfg_d.mask[mask_idx] = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        if (ctrl_hit) begin
            reg_rdata = cfg_q.ctrl[ctrl_idx];
        end else if (mask_hit) begin
            reg_rdata = cfg_q.mask[mask_idx];
        end else begin
            reg_rdata = '0;
        end
    end

    assign mode_flat = cfg_q.ctrl;
    assign mask_flat = cfg_q.mask;

endmodule

// File: rtl/edge_line_cell.sv
module edge_line_cell (
    input  logic       cur,
    input  logic       prev,
    input  logic [1:0] mode,
    input  logic       mask,
    output logic       hit
);
    import edge_det_pkg::*;

    logic raw;

    always_comb begin
        case (mode)
            MODE_RISE: raw = cur & ~prev;
            MODE_FALL: raw = ~cur & prev;
            MODE_BOTH: raw = cur ^ prev;
            default:   raw = 1'b0;
        endcase
        hit = raw & ~mask;
    end

endmodule

// File: rtl/edge_detect_array.sv
module edge_detect_array #(
    parameter int NUM_LINES = 256
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [NUM_LINES-1:0]                         lines_in,
    input  logic [edge_det_pkg::MODE_BITS*NUM_LINES-1:0] mode_flat,
    input  logic [NUM_LINES-1:0]                         mask_flat,
    output logic [NUM_LINES-1:0]                         edge_pulse,
    output logic                                         any_edge
);
    localparam int MB = edge_det_pkg::MODE_BITS;

    typedef struct packed {
        logic [NUM_LINES-1:0] samp;
        logic [NUM_LINES-1:0] prev;
        logic [1:0]           fill;
        logic [NUM_LINES-1:0] pulse;
        logic                 any;
    } det_t;

    det_t                 st_d, st_q;
    logic [NUM_LINES-1:0] hit;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        edge_line_cell u_cell (
            .cur  (st_q.samp[i]),
            .prev (st_q.prev[i]),
            .mode (mode_flat[MB*i +: MB]),
            .mask (mask_flat[i]),
            .hit  (hit[i])
        );
    end

    // fill[1] is set once samp and prev both hold post-reset samples
    always_comb begin
        st_d      = st_q;
        st_d.samp = lines_in;
        st_d.prev = st_q.samp;
        st_d.fill = {st_q.fill[0], 1'b1};
        st_d.pulse = st_q.fill[1] ? hit : '0;
        st_d.any   = st_q.fill[1] & (|hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_pulse = st_q.pulse;
    assign any_edge   = st_q.any;

endmodule

// File: rtl/multi_edge_detector.sv
module multi_edge_detector #(
    parameter int                NUM_LINES = 256,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 'h808,
    parameter logic [ADDR_W-1:0] MASK_BASE = 'h848
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] edge_pulse,
    output logic                 any_edge
);
    localparam int MODE_W = edge_det_pkg::MODE_BITS * NUM_LINES;

    logic [MODE_W-1:0]    mode_flat;
    logic [NUM_LINES-1:0] mask_flat;

    edge_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CTRL_BASE (CTRL_BASE),
        .MASK_BASE (MASK_BASE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mode_flat (mode_flat),
        .mask_flat (mask_flat)
    );

    edge_detect_array #(
        .NUM_LINES (NUM_LINES)
    ) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines_in   (lines_in),
        .mode_flat  (mode_flat),
        .mask_flat  (mask_flat),
        .edge_pulse (edge_pulse),
        .any_edge   (any_edge)
    );

endmodule

// File: rtl/edge_det_checker.sv
module edge_det_checker #(
    parameter int NUM_LINES = 256
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic [NUM_LINES-1:0]                         lines_in,
    input logic [edge_det_pkg::MODE_BITS*NUM_LINES-1:0] mode_flat,
    input logic [NUM_LINES-1:0]                         mask_flat,
    input logic [NUM_LINES-1:0]                         edge_pulse,
    input logic                                         any_edge
);
    localparam int MB = edge_det_pkg::MODE_BITS;

    // history: h1 = input one edge ago, h2 two, h3 three; m1/k1 config one edge ago
    logic [NUM_LINES-1:0]    h1, h2, h3, k1;
    logic [MB*NUM_LINES-1:0] m1;
    logic [NUM_LINES-1:0]    allowed, rsvd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1 <= '0;
            h2 <= '0;
            h3 <= '0;
            k1 <= '0;
            m1 <= '0;
        end else begin
            h1 <= lines_in;
            h2 <= h1;
            h3 <= h2;
            k1 <= mask_flat;
            m1 <= mode_flat;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            rsvd[i] = (m1[MB*i +: MB] == 2'b11);
            case (m1[MB*i +: MB])
                2'b00:   allowed[i] = h2[i] & ~h3[i];
                2'b01:   allowed[i] = ~h2[i] & h3[i];
                2'b10:   allowed[i] = h2[i] ^ h3[i];
                default: allowed[i] = 1'b0;
            endcase
        end
    end

    // R2 R3 R4: a pulse only where the chosen transition took place
    p_pulse_justified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse & ~allowed) == '0);

    p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse & rsvd) == '0);

    p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse & k1) == '0);

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (edge_pulse == '0));

    p_any_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge == (|edge_pulse));

endmodule

bind multi_edge_detector edge_det_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines_in   (lines_in),
    .mode_flat  (mode_flat),
    .mask_flat  (mask_flat),
    .edge_pulse (edge_pulse),
    .any_edge   (any_edge)
);

// File: tb/multi_edge_detector_test.sv
module multi_edge_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 256;

    // vector: {line[7:0], mode[1:0], mask, before, after, expect}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {8'd0,   2'b00, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd0,   2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd17,  2'b01, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd17,  2'b01, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd100, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd100, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd255, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd255, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd40,  2'b00, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd40,  2'b00, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd31,  2'b10, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd32,  2'b01, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [11:0]   reg_addr;
    logic          reg_wr_en;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  lines;
    logic [N-1:0]  edge_pulse;
    logic          any_edge;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] ctrl_sh [16];
    logic [31:0] mask_sh [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    multi_edge_detector uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lines_in   (lines),
        .edge_pulse (edge_pulse),
        .any_edge   (any_edge)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic prog(input int idx, input logic [1:0] m, input logic k);
        ctrl_sh[idx/16][2*(idx%16) +: 2] = m;
        mask_sh[idx/32][idx%32]          = k;
        wr(12'(32'h808 + 4*(idx/16)), ctrl_sh[idx/16]);
        wr(12'(32'h848 + 4*(idx/32)), mask_sh[idx/32]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1: watchdog, actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [N-1:0] one;
        for (int i = 0; i < 16; i++) ctrl_sh[i] = '0;
        for (int i = 0; i < 8; i++) mask_sh[i] = '0;
        rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        lines = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: inputs high across reset give no pulse while history fills
        for (int c = 0; c < 4; c++) begin
            chk("R10 quiet after reset", edge_pulse, '0);
            chk("R10 any_edge after reset", N'(any_edge), '0);
            @(negedge clk);
        end
        for (int w = 0; w < 16; w++) begin
            rd(12'(32'h808 + 4*w), d);
            chk("R10 mode word reset", N'(d), '0);
        end
        for (int w = 0; w < 8; w++) begin
            rd(12'(32'h848 + 4*w), d);
            chk("R10 mask word reset", N'(d), '0);
        end
        // falling transition under default rising mode is silent (R2)
        @(negedge clk); lines = '0;
        repeat (2) @(negedge clk);
        chk("R2 fall ignored in rising mode", edge_pulse, '0);
        repeat (2) @(negedge clk);

        // R8 read back
        wr(12'h81C, 32'hA5A5_5A5A);
        wr(12'h854, 32'h1234_5678);
        rd(12'h81C, d); chk("R8 mode word readback", N'(d), N'(32'hA5A5_5A5A));
        rd(12'h854, d); chk("R8 mask word readback", N'(d), N'(32'h1234_5678));
        wr(12'h81C, 32'h0);
        wr(12'h854, 32'h0);

        // R9 unmapped and unaligned
        wr(12'h808, 32'hFFFF_FFFF);
        rd(12'h80A, d); chk("R9 unaligned read", N'(d), '0);
        rd(12'h804, d); chk("R9 below range read", N'(d), '0);
        rd(12'h868, d); chk("R9 above range read", N'(d), '0);
        wr(12'h808, 32'h0);
        wr(12'h868, 32'hFFFF_FFFF);
        wr(12'h80E, 32'h0000_0005);
        wr(12'h800, 32'hFFFF_FFFF);
        for (int w = 0; w < 8; w++) begin
            rd(12'(32'h848 + 4*w), d);
            chk("R9 stray write left mask intact", N'(d), '0);
        end
        rd(12'h80C, d); chk("R9 unaligned write ignored", N'(d), '0);

        // R7: line 255 field is bits 31:30 of word 15; set falling mode
        one = '0; one[255] = 1'b1;
        wr(12'h844, 32'h4000_0000);
        @(negedge clk); lines[255] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 line 255 rising ignored in falling mode", edge_pulse, '0);
        repeat (2) @(negedge clk);
        lines[255] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 line 255 falling pulse", edge_pulse, one);
        @(negedge clk);
        chk("R12 pulse one cycle", edge_pulse, '0);
        // R6: bit 31 of mask word 7 suppresses line 255
        wr(12'h864, 32'h8000_0000);
        lines[255] = 1'b1;
        repeat (4) @(negedge clk);
        lines[255] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 line 255 suppressed", edge_pulse, '0);
        chk("R6 any_edge suppressed", N'(any_edge), '0);
        wr(12'h844, 32'h0);
        wr(12'h864, 32'h0);

        // R11: two simultaneous rising lines
        one = '0; one[3] = 1'b1; one[200] = 1'b1;
        @(negedge clk); lines[3] = 1'b1; lines[200] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 two pulses", edge_pulse, one);
        chk("R11 any_edge high", N'(any_edge), N'(1));
        @(negedge clk);
        chk("R11 any_edge low", N'(any_edge), '0);
        lines[3] = 1'b0; lines[200] = 1'b0;
        repeat (4) @(negedge clk);

        // table walk: R1..R6
        for (int v = 0; v < NV; v++) begin
            int          idx;
            logic [1:0]  m;
            logic        k, bef, aft, ex;
            string       tag;
            logic [N-1:0] exp;
            idx = int'(VEC[v][13:6]);
            m   = VEC[v][5:4];
            k   = VEC[v][3];
            bef = VEC[v][2];
            aft = VEC[v][1];
            ex  = VEC[v][0];
            tag = k ? "R6" : (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : (m == 2'b10) ? "R4" : "R5";
            prog(idx, m, k);
            lines[idx] = bef;
            repeat (4) @(negedge clk);
            chk("R1 idle before transition", edge_pulse, '0);
            lines[idx] = aft;
            repeat (2) @(negedge clk);
            exp = '0; exp[idx] = ex;
            chk({tag, " table pulse"}, edge_pulse, exp);
            chk("R11 any_edge follows table", N'(any_edge), N'(ex));
            @(negedge clk);
            chk("R12 table pulse ends", edge_pulse, '0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule